// File: doc/BRIEF.md
# Receive Guard and Empty-Slot Timers

This block sits in the digital receive path of a contactless reader. It runs two timers. The guard timer keeps the receive decoders in reset for a set interval once a transmission has finished, so that ringing left over from the transmitter cannot be decoded as a reply. The slot timer starts when an anticollision slot opens and stops when a tag reply begins. If the programmed wait runs out with no reply, it raises a one-cycle interrupt and sets a sticky status flag. The host then does not need to time empty slots itself.

A single free-running prescaler clocks both timers. It produces a fine tick every `FINE_DIV` clocks (128 by default, about 9.44 µs at 13.56 MHz) and a coarse tick every `COARSE_DIV` clocks (512 by default, about 37.76 µs). Each timer has an 8-bit wait register. A write of a protocol code loads both wait registers from a built-in table of per-protocol defaults. Host writes to either wait register that come after the protocol write replace those defaults.

Top module: `rx_timer_unit`

## Requirements
- R1: After reset, `dec_rst`, `nr_irq` and `nr_flag` are 0, `guard_val` is 0x1F and `noresp_val` is 0x0E. These are the protocol-0 defaults.
- R2: A `proto_wr` pulse loads both wait registers on the next clock from the code on `proto_code`. The (guard, slot) values are: code 0 gives (0x1F, 0x0E), code 1 gives (0x1F, 0x15), code 2 gives (0x0E, 0x0E) and code 3 gives (0x07, 0x1C).
- R3: `guard_wr` and `noresp_wr` load their wait register from the write data on the next clock. If a protocol write happens in the same cycle, the host write wins for that register.
- R4: A fine tick occurs in clock cycle k when k mod `FINE_DIV` equals `FINE_DIV`-1. Here k counts the rising edges after reset release, starting at 0. A `tx_end` pulse with a guard value G other than 0 sets `dec_rst` from the next cycle. `dec_rst` clears at the edge of the G-th fine tick that follows the strobe.
- R5: A `tx_end` pulse while the guard value is 0 leaves `dec_rst` low.
- R6: A `tx_end` pulse while the guard timer is running restarts it from the current guard value.
- R7: A coarse tick occurs in cycle k when k mod `COARSE_DIV` equals `COARSE_DIV`-1. A `slot_start` pulse with a slot value N other than 0 arms the slot timer. If no reply start arrives, the N-th coarse tick after the strobe makes `nr_irq` high for exactly the next cycle and sets `nr_flag`.
- R8: A `resp_start` pulse while the slot timer is armed disarms it, and no interrupt follows. `resp_start` has no effect when the timer is idle. `slot_start` in the same cycle takes priority over it.
- R9: A `slot_start` pulse with a slot value of 0 produces `nr_irq` in the next cycle.
- R10: A `slot_start` pulse while the slot timer is armed restarts the countdown from the current slot value.
- R11: `nr_flag` stays set until a `flag_clr` pulse clears it. If an interrupt and a clear arrive together, the flag stays set.
- R12: Each timer captures its wait value at its start strobe. Writing to a wait register while the timer runs does not change the interval already in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_end | input | 1 | Pulse at the end of a transmission |
| slot_start | input | 1 | Pulse at the opening of an anticollision slot |
| resp_start | input | 1 | Pulse when a tag reply begins |
| proto_wr | input | 1 | Protocol select write strobe |
| proto_code | input | 2 | Protocol code for the table lookup |
| guard_wr | input | 1 | Host write strobe for the guard wait value |
| guard_wdata | input | 8 | Host data for the guard wait value |
| noresp_wr | input | 1 | Host write strobe for the slot wait value |
| noresp_wdata | input | 8 | Host data for the slot wait value |
| flag_clr | input | 1 | Clears the no-response status flag |
| dec_rst | output | 1 | Holds the receive decoders in reset |
| nr_irq | output | 1 | One-cycle no-response interrupt |
| nr_flag | output | 1 | Sticky no-response status flag |
| guard_val | output | 8 | Current guard wait value |
| noresp_val | output | 8 | Current slot wait value |

## Verification
The hardest cases to reach are strobes that land on a prescaler tick, because the prescaler runs freely and its phase is not visible at the ports. Two of these matter most: a restart that lands on the tick that would otherwise have expired the timer, and a reply start in the very cycle of expiry. To reach them, the stimulus first steps a strobe offset across every coarse-tick phase in turn. It then runs a long pseudo-random stretch in which strobes, host writes and clears overlap. A behavioural model counts cycles since reset and checks every output on every clock.

// File: rtl/rxt_pkg.sv
package rxt_pkg;

   localparam int unsigned TMR_W   = 8;
   localparam int unsigned PROTO_W = 2;

   typedef logic [TMR_W-1:0]   tmr_val_t;
   typedef logic [PROTO_W-1:0] proto_t;

   // per-protocol guard interval, in fine steps
   function automatic tmr_val_t guard_default(input proto_t code);
      case (code)
         2'd1:    return 8'h1F;
         2'd2:    return 8'h0E;
         2'd3:    return 8'h07;
         default: return 8'h1F;
      endcase
   endfunction

   // per-protocol empty-slot wait, in coarse steps
   function automatic tmr_val_t noresp_default(input proto_t code);
      case (code)
         2'd1:    return 8'h15;
         2'd2:    return 8'h0E;
         2'd3:    return 8'h1C;
         default: return 8'h0E;
      endcase
   endfunction

endpackage

// File: rtl/rxt_prescaler.sv
module rxt_prescaler #(
   parameter int unsigned FINE_DIV   = 128,
   parameter int unsigned COARSE_DIV = 512
) (
   input  logic clk,
   input  logic rst_n,
   output logic fine_tick,
   output logic coarse_tick
);
   localparam int unsigned FW = $clog2(FINE_DIV);
   localparam int unsigned CW = $clog2(COARSE_DIV);

   logic [CW-1:0] phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase_q <= '0;
      else        phase_q <= phase_q + 1'b1;
   end

   assign fine_tick = &phase_q[FW-1:0];

   generate
      if (COARSE_DIV == FINE_DIV) begin : g_same_rate
         assign coarse_tick = fine_tick;
      end else begin : g_split_rate
         assign coarse_tick = &phase_q;
      end
   endgenerate

endmodule

// File: rtl/rxt_preset_regs.sv
module rxt_preset_regs
   import rxt_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     proto_wr,
   input  proto_t   proto_code,
   input  logic     guard_wr,
   input  tmr_val_t guard_wdata,
   input  logic     noresp_wr,
   input  tmr_val_t noresp_wdata,
   output tmr_val_t guard_val,
   output tmr_val_t noresp_val
);
   tmr_val_t guard_q, noresp_q;
   tmr_val_t guard_d, noresp_d;

   always_comb begin
      guard_d  = guard_q;
      noresp_d = noresp_q;
      if (proto_wr) begin
         guard_d  = guard_default(proto_code);
         noresp_d = noresp_default(proto_code);
      end
      if (guard_wr)  guard_d  = guard_wdata;
      if (noresp_wr) noresp_d = noresp_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         guard_q  <= guard_default('0);
         noresp_q <= noresp_default('0);
      end else begin
         guard_q  <= guard_d;
         noresp_q <= noresp_d;
      end
   end

   assign guard_val  = guard_q;
   assign noresp_val = noresp_q;

endmodule

// File: rtl/rxt_guard_timer.sv
module rxt_guard_timer
   import rxt_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     tick,
   input  logic     start,
   input  tmr_val_t load_val,
   output logic     hold
);
   tmr_val_t remain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         remain_q <= '0;
      else if (start)                     remain_q <= load_val;
      else if (tick && remain_q != '0)    remain_q <= remain_q - 1'b1;
   end

   assign hold = (remain_q != '0);

endmodule

// File: rtl/rxt_noresp_timer.sv
module rxt_noresp_timer
   import rxt_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     tick,
   input  logic     arm,
   input  logic     resp,
   input  logic     clr,
   input  tmr_val_t load_val,
   output logic     irq,
   output logic     flag
);
   logic     run_q, run_d;
   tmr_val_t cnt_q, cnt_d;
   logic     expire;
   logic     irq_q, flag_q;

   always_comb begin
      run_d  = run_q;
      cnt_d  = cnt_q;
      expire = 1'b0;
      if (arm) begin
         if (load_val == '0) begin
            run_d  = 1'b0;
            expire = 1'b1;
         end else begin
            run_d = 1'b1;
            cnt_d = load_val;
         end
      end else if (resp && run_q) begin
         run_d = 1'b0;
      end else if (tick && run_q) begin
         if (cnt_q == tmr_val_t'(1)) begin
            run_d  = 1'b0;
            expire = 1'b1;
         end else begin
            cnt_d = cnt_q - 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         cnt_q  <= '0;
         irq_q  <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         run_q <= run_d;
         cnt_q <= cnt_d;
         irq_q <= expire;
         if (expire)   flag_q <= 1'b1;
         else if (clr) flag_q <= 1'b0;
      end
   end

   assign irq  = irq_q;
   assign flag = flag_q;

endmodule

// File: rtl/rx_timer_unit.sv
module rx_timer_unit
   import rxt_pkg::*;
#(
   parameter int unsigned FINE_DIV   = 128,
   parameter int unsigned COARSE_DIV = 512
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tx_end,
   input  logic       slot_start,
   input  logic       resp_start,
   input  logic       proto_wr,
   input  logic [1:0] proto_code,
   input  logic       guard_wr,
   input  logic [7:0] guard_wdata,
   input  logic       noresp_wr,
   input  logic [7:0] noresp_wdata,
   input  logic       flag_clr,
   output logic       dec_rst,
   output logic       nr_irq,
   output logic       nr_flag,
   output logic [7:0] guard_val,
   output logic [7:0] noresp_val
);
   // elaboration-time parameter checks
   generate
      if (FINE_DIV < 2 || (FINE_DIV & (FINE_DIV - 1)) != 0) begin : g_bad_fine
         $error("FINE_DIV must be a power of two of at least 2");
      end
      if (COARSE_DIV < FINE_DIV || (COARSE_DIV & (COARSE_DIV - 1)) != 0) begin : g_bad_coarse
         $error("COARSE_DIV must be a power of two not below FINE_DIV");
      end
   endgenerate

   logic     fine_tick, coarse_tick;
   tmr_val_t guard_q, noresp_q;

   rxt_prescaler #(.FINE_DIV(FINE_DIV), .COARSE_DIV(COARSE_DIV)) presc_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .fine_tick   (fine_tick),
      .coarse_tick (coarse_tick)
   );

   rxt_preset_regs regs_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .proto_wr     (proto_wr),
      .proto_code   (proto_code),
      .guard_wr     (guard_wr),
      .guard_wdata  (guard_wdata),
      .noresp_wr    (noresp_wr),
      .noresp_wdata (noresp_wdata),
      .guard_val    (guard_q),
      .noresp_val   (noresp_q)
   );

   rxt_guard_timer guard_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (fine_tick),
      .start    (tx_end),
      .load_val (guard_q),
      .hold     (dec_rst)
   );

   rxt_noresp_timer slot_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (coarse_tick),
      .arm      (slot_start),
      .resp     (resp_start),
      .clr      (flag_clr),
      .load_val (noresp_q),
      .irq      (nr_irq),
      .flag     (nr_flag)
   );

   assign guard_val  = guard_q;
   assign noresp_val = noresp_q;

endmodule

// File: rtl/rxt_timer_checks.sv
module rxt_timer_checks
   import rxt_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       tx_end,
   input logic       slot_start,
   input logic       resp_start,
   input logic       proto_wr,
   input logic [1:0] proto_code,
   input logic       guard_wr,
   input logic [7:0] guard_wdata,
   input logic       flag_clr,
   input logic       dec_rst,
   input logic       nr_irq,
   input logic       nr_flag,
   input logic [7:0] guard_val,
   input logic [7:0] noresp_val
);
   assert_proto_preset_R2: assert property (@(posedge clk) disable iff (!rst_n)
      proto_wr && !guard_wr |=> guard_val == guard_default($past(proto_code)));

   assert_host_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      guard_wr |=> guard_val == $past(guard_wdata));

   assert_guard_arm_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_end && guard_val != 8'h00 |=> dec_rst);

   assert_guard_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dec_rst) |-> $past(tx_end));

   assert_guard_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_end && guard_val == 8'h00 |=> !dec_rst);

   assert_resp_cancel_R8: assert property (@(posedge clk) disable iff (!rst_n)
      resp_start && !slot_start |=> !nr_irq);

   assert_zero_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
      slot_start && noresp_val == 8'h00 |=> nr_irq);

   assert_irq_sets_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
      nr_irq |-> nr_flag);

   assert_flag_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(nr_flag) |-> $past(flag_clr));

endmodule

bind rx_timer_unit rxt_timer_checks chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .tx_end      (tx_end),
   .slot_start  (slot_start),
   .resp_start  (resp_start),
   .proto_wr    (proto_wr),
   .proto_code  (proto_code),
   .guard_wr    (guard_wr),
   .guard_wdata (guard_wdata),
   .flag_clr    (flag_clr),
   .dec_rst     (dec_rst),
   .nr_irq      (nr_irq),
   .nr_flag     (nr_flag),
   .guard_val   (guard_val),
   .noresp_val  (noresp_val)
);

// File: tb/rx_timer_unit_tb_top.sv
`timescale 1ns/1ps
module rx_timer_unit_tb_top;
   localparam int F = 4;
   localparam int C = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tx_end = 0, slot_start = 0, resp_start = 0, proto_wr = 0;
   logic [1:0] proto_code = 0;
   logic       guard_wr = 0, noresp_wr = 0, flag_clr = 0;
   logic [7:0] guard_wdata = 0, noresp_wdata = 0;
   logic       dec_rst, nr_irq, nr_flag;
   logic [7:0] guard_val, noresp_val;

   int checks = 0;
   int failures = 0;
   int irq_cnt = 0;
   int hold_cnt = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   rx_timer_unit #(.FINE_DIV(F), .COARSE_DIV(C)) dut_i (
      .clk(clk), .rst_n(rst_n), .tx_end(tx_end), .slot_start(slot_start),
      .resp_start(resp_start), .proto_wr(proto_wr), .proto_code(proto_code),
      .guard_wr(guard_wr), .guard_wdata(guard_wdata), .noresp_wr(noresp_wr),
      .noresp_wdata(noresp_wdata), .flag_clr(flag_clr), .dec_rst(dec_rst),
      .nr_irq(nr_irq), .nr_flag(nr_flag), .guard_val(guard_val),
      .noresp_val(noresp_val));

   function automatic int exp_guard(int code);
      case (code) 1: return 'h1F; 2: return 'h0E; 3: return 'h07; default: return 'h1F; endcase
   endfunction
   function automatic int exp_slot(int code);
      case (code) 1: return 'h15; 2: return 'h0E; 3: return 'h1C; default: return 'h0E; endcase
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference model, cycle indexed from reset release
   int  m_cyc, m_g, m_n;
   bit  m_run, m_irq, m_flag;
   int  m_greg, m_nreg;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cyc = 0; m_g = 0; m_n = 0; m_run = 0; m_irq = 0; m_flag = 0;
         m_greg = 'h1F; m_nreg = 'h0E;
      end else begin
         bit tf, tc, fire;
         tf = (m_cyc % F) == F - 1;
         tc = (m_cyc % C) == C - 1;
         m_cyc++;
         if (tx_end) m_g = m_greg;
         else if (tf && m_g > 0) m_g--;
         fire = 0;
         if (slot_start) begin
            if (m_nreg == 0) begin fire = 1; m_run = 0; end
            else begin m_run = 1; m_n = m_nreg; end
         end else if (resp_start && m_run) m_run = 0;
         else if (tc && m_run) begin
            if (m_n == 1) begin fire = 1; m_run = 0; end
            else m_n--;
         end
         m_irq = fire;
         if (fire) m_flag = 1;
         else if (flag_clr) m_flag = 0;
         if (proto_wr) begin m_greg = exp_guard(proto_code); m_nreg = exp_slot(proto_code); end
         if (guard_wr) m_greg = guard_wdata;
         if (noresp_wr) m_nreg = noresp_wdata;
      end
   end

   // per-clock comparison, sampled on the falling edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk("R4/R5/R6/R12 dec_rst", dec_rst, (m_g != 0));
         chk("R7/R8/R9/R10 nr_irq", nr_irq, m_irq);
         chk("R11 nr_flag", nr_flag, m_flag);
         chk("R2/R3 guard_val", guard_val, m_greg);
         chk("R2/R3 noresp_val", noresp_val, m_nreg);
         if (nr_irq) irq_cnt++;
         if (dec_rst) hold_cnt++;
      end
   end

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse_tx();
      @(negedge clk); tx_end = 1; @(negedge clk); tx_end = 0;
   endtask
   task automatic pulse_slot();
      @(negedge clk); slot_start = 1; @(negedge clk); slot_start = 0;
   endtask
   task automatic pulse_resp();
      @(negedge clk); resp_start = 1; @(negedge clk); resp_start = 0;
   endtask
   task automatic wr_guard(input int v);
      @(negedge clk); guard_wr = 1; guard_wdata = 8'(v); @(negedge clk); guard_wr = 0;
   endtask
   task automatic wr_slot(input int v);
      @(negedge clk); noresp_wr = 1; noresp_wdata = 8'(v); @(negedge clk); noresp_wr = 0;
   endtask
   task automatic clear_flag();
      @(negedge clk); flag_clr = 1; @(negedge clk); flag_clr = 0;
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin : watchdog
      #(200000 * 5);
      if (!finished) begin
         finished = 1;
         failures++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin : stim
      int base;
      idle(3);
      @(negedge clk); rst_n = 1;
      // R1 reset state
      chk("R1 dec_rst", dec_rst, 0);
      chk("R1 nr_irq", nr_irq, 0);
      chk("R1 nr_flag", nr_flag, 0);
      chk("R1 guard_val", guard_val, 'h1F);
      chk("R1 noresp_val", noresp_val, 'h0E);

      // R2 protocol presets
      for (int c = 3; c >= 0; c--) begin
         @(negedge clk); proto_wr = 1; proto_code = 2'(c);
         @(negedge clk); proto_wr = 0;
         chk("R2 guard preset", guard_val, exp_guard(c));
         chk("R2 slot preset", noresp_val, exp_slot(c));
      end

      // R3 host write, and host write winning over a coincident preset
      wr_guard('h05);
      chk("R3 guard write", guard_val, 'h05);
      @(negedge clk); proto_wr = 1; proto_code = 2; noresp_wr = 1; noresp_wdata = 'h33;
      @(negedge clk); proto_wr = 0; noresp_wr = 0;
      chk("R3 preset guard", guard_val, 'h0E);
      chk("R3 host wins slot", noresp_val, 'h33);

      // R4 guard length with G=3: between 2*F+1 and 3*F cycles
      wr_guard(3);
      hold_cnt = 0; pulse_tx(); idle(20);
      checks++;
      if (hold_cnt < 2*F+1 || hold_cnt > 3*F) begin
         failures++; $display("FAIL R4 hold cycles actual=%0d expected=%0d..%0d", hold_cnt, 2*F+1, 3*F);
      end

      // R5 zero guard
      wr_guard(0); hold_cnt = 0; pulse_tx(); idle(8);
      chk("R5 no guard", hold_cnt, 0);

      // R6 restart while running
      wr_guard(3); hold_cnt = 0; pulse_tx(); idle(5); pulse_tx(); idle(20);
      checks++;
      if (hold_cnt <= 3*F) begin
         failures++; $display("FAIL R6 hold cycles actual=%0d expected=>%0d", hold_cnt, 3*F);
      end

      // R12 value captured at start
      hold_cnt = 0; pulse_tx(); wr_guard('h40); idle(20);
      checks++;
      if (hold_cnt > 3*F) begin
         failures++; $display("FAIL R12 hold cycles actual=%0d expected=<=%0d", hold_cnt, 3*F);
      end

      // R7 timeout raises interrupt and flag
      wr_slot(2); base = irq_cnt; pulse_slot(); idle(40);
      chk("R7 irq count", irq_cnt - base, 1);
      chk("R7 flag set", nr_flag, 1);
      clear_flag();
      chk("R11 flag cleared", nr_flag, 0);

      // R8 reply cancels, idle reply ignored
      wr_slot(3); base = irq_cnt; pulse_slot(); idle(5); pulse_resp(); idle(70);
      chk("R8 cancelled", irq_cnt - base, 0);
      pulse_resp(); idle(5);
      chk("R8 idle reply", irq_cnt - base, 0);

      // R9 zero wait
      wr_slot(0); pulse_slot();
      chk("R9 immediate irq", nr_irq, 1);
      clear_flag();

      // R11 set and clear together keep flag
      @(negedge clk); slot_start = 1; flag_clr = 1;
      @(negedge clk); slot_start = 0; flag_clr = 0;
      chk("R11 set wins", nr_flag, 1);
      clear_flag();

      // R10 repeated restart never expires, then one expiry
      wr_slot(2); base = irq_cnt;
      for (int i = 0; i < 6; i++) begin pulse_slot(); idle(8); end
      chk("R10 no expiry while restarted", irq_cnt - base, 0);
      idle(40);
      chk("R10 single expiry", irq_cnt - base, 1);

      // phase sweep: strobes at every coarse phase (R4 R7 R8)
      wr_guard(1); wr_slot(1);
      for (int ph = 0; ph < C; ph++) begin
         idle(ph);
         @(negedge clk); tx_end = 1; slot_start = 1;
         @(negedge clk); tx_end = 0; slot_start = 0;
         idle(ph % 3 == 0 ? C - 1 : ph);
         pulse_resp(); idle(C);
      end

      // pseudo-random overlap of all stimulus
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         tx_end     = ($urandom % 23) == 0;
         slot_start = ($urandom % 29) == 0;
         resp_start = ($urandom % 31) == 0;
         flag_clr   = ($urandom % 17) == 0;
         proto_wr   = ($urandom % 97) == 0;
         proto_code = 2'($urandom);
         guard_wr   = ($urandom % 89) == 0;
         guard_wdata = 8'($urandom % 5);
         noresp_wr  = ($urandom % 83) == 0;
         noresp_wdata = 8'($urandom % 4);
      end
      @(negedge clk);
      tx_end = 0; slot_start = 0; resp_start = 0; flag_clr = 0;
      proto_wr = 0; guard_wr = 0; noresp_wr = 0;
      idle(10);

      finished = 1;
      summary();
      $finish;
   end
endmodule